// File: doc/BRIEF.md
# Prescaled Capture/Compare Timer

This block is a 32-bit up-counter with a selectable time base, a capture register fed from an external pin and a compare register that drives an output pin. The time base comes from the system clock taken directly, from the system clock divided by sixteen, or from rising edges of the external pin. An 8-bit programmable prescaler sits between the time base and the counter. Software sets up the timer through a small word-wide register port. Reads have no side effects.

The block sees two events: a capture on a chosen edge of the external pin, and a reference match. Each event has its own small state machine with three states. `EV_IDLE` means nothing is pending. `EV_SWAIT` means the event is waiting for software to clear it, and in interrupt mode it raises the interrupt line. `EV_DMAWAIT` means the event is holding its DMA request until the acknowledge arrives. The transitions are:

- `EV_IDLE` to `EV_SWAIT` on an event in flag-only or interrupt mode.
- `EV_IDLE` to `EV_DMAWAIT` on an event in DMA mode.
- `EV_SWAIT` to `EV_IDLE` on a software write-one-to-clear with no new event in the same cycle.
- `EV_DMAWAIT` to `EV_IDLE` on the acknowledge.

A register map on a 3-bit address:

- 0 is the control word.
- 1 is the reference value.
- 2 is the capture value, read-only.
- 3 is the counter. A write loads it.
- 4 is the status word.

Top module: `ptmr_top`

## Requirements
- R1: After reset every register reads zero, `tout` is low, `irq` is low and both DMA requests are low.
- R2: A write to address 3 loads the counter and restarts the time base and the prescaler. With control bit 0 (enable) clear, the counter holds. With it set, the counter rises by one per prescaler tick and wraps from 0xFFFFFFFF to 0.
- R3: With control bits [2:1] = 0 (system clock), the prescale value N in control bits [23:16] gives one count every N+1 clock cycles. So a value of 0 divides by 1 and 255 divides by 256.
- R4: With control bits [2:1] = 1 (system clock divided by 16), the counter advances once every 16·(N+1) clock cycles.
- R5: With control bits [2:1] = 2 (external), the pin `tin` passes through two synchronizing flip-flops. Every N+1 synchronized rising edges advance the counter by one. A value of 3 stops the time base.
- R6: A reference match happens on a tick while the counter equals the reference value. The counter then becomes 0 if control bit 5 (restart) is set, and takes its normal increment if the bit is clear. The match sets status bit 1.
- R7: With control bit 6 clear, `tout` is high for exactly one cycle after each match. With it set, `tout` inverts on each match.
- R8: Control bits [4:3] select the capture edge of the synchronized `tin`: 0 none, 1 rising, 2 falling, 3 both. A selected edge copies the counter into the capture register and sets status bit 0. Unselected edges change neither.
- R9: Request mode per event: control bits [9:8] for capture and [11:10] for match. The codes are 0 flag only, 1 interrupt, 2 DMA. `irq` is high while an event in mode 1 is pending. `dma_req[0]` (capture) and `dma_req[1]` (match) are high while the event waits in mode 2.
- R10: Writing 1 to a status bit at address 4 clears a pending event in flag-only or interrupt mode. Writing 1 has no effect on an event waiting for DMA.
- R11: `dma_ack[i]` clears the DMA-pending event i. An acknowledge has no effect on an event pending in flag-only or interrupt mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register address for read and write |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| tin | input | 1 | External clock / capture pin, asynchronous |
| tout | output | 1 | Compare output pin |
| irq | output | 1 | Interrupt request |
| dma_req | output | 2 | DMA requests: bit 0 capture, bit 1 match |
| dma_ack | input | 2 | DMA acknowledges, same bit order |

## Verification
The hardest case to reach is a match event that sits in `EV_DMAWAIT` while software tries to clear it and while an acknowledge goes to the wrong kind of pending event. The bench reaches this by producing one match at a known count and then clearing the enable bit so that no further match can occur. It then applies the write-one-to-clear and the acknowledge in separate steps and reads the status between them. Prescaler and restart periods are swept over small ranges, and each counter value is predicted by integer division and modulo from the number of clock edges since the load.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

    typedef enum logic [1:0] {
        SRC_SYS1  = 2'd0,
        SRC_SYS16 = 2'd1,
        SRC_EXT   = 2'd2,
        SRC_OFF   = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2,
        EDGE_BOTH = 2'd3
    } edge_e;

    typedef enum logic [1:0] {
        REQ_FLAG = 2'd0,
        REQ_IRQ  = 2'd1,
        REQ_DMA  = 2'd2,
        REQ_RSVD = 2'd3
    } req_e;

    typedef struct packed {
        logic [7:0] presc;
        logic [3:0] spare_hi;
        req_e       match_req;
        req_e       cap_req;
        logic       spare_lo;
        logic       toggle;
        logic       restart;
        edge_e      cap_edge;
        src_e       src;
        logic       en;
    } ctrl_t;

    localparam logic [2:0] A_CTRL = 3'd0;
    localparam logic [2:0] A_REFV = 3'd1;
    localparam logic [2:0] A_CAPV = 3'd2;
    localparam logic [2:0] A_CNT  = 3'd3;
    localparam logic [2:0] A_STAT = 3'd4;

endpackage

// File: rtl/ptmr_sync.sv
module ptmr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-1:0], pin};
    end

    assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];
    assign fall = ~chain_q[STAGES-1] & chain_q[STAGES];

endmodule

// File: rtl/ptmr_tick.sv
module ptmr_tick
    import ptmr_pkg::*;
#(
    parameter int PW   = 8,
    parameter int DIVW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  src_e          src,
    input  logic          ext_rise,
    input  logic [PW-1:0] presc,
    input  logic          clr,
    output logic          tick
);
    localparam logic [PW-1:0]   P_ONE = 1;
    localparam logic [DIVW-1:0] D_ONE = 1;

    logic [DIVW-1:0] div_q;
    logic [PW-1:0]   p_q;
    logic            src_pulse;

    always_comb begin
        unique case (src)
            SRC_SYS1:  src_pulse = en;
            SRC_SYS16: src_pulse = en && (div_q == '1);
            SRC_EXT:   src_pulse = en && ext_rise;
            default:   src_pulse = 1'b0;
        endcase
    end

    assign tick = src_pulse && (p_q >= presc);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
            p_q   <= '0;
        end else if (clr) begin
            div_q <= '0;
            p_q   <= '0;
        end else begin
            if (en && src == SRC_SYS16) div_q <= div_q + D_ONE;
            if (src_pulse)              p_q   <= tick ? '0 : p_q + P_ONE;
        end
    end

    // R3: with a nonzero, unchanged prescale, two ticks never come back to back
    a_r3_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clr) |=> (!tick || presc == '0 || presc != $past(presc)));

endmodule

// File: rtl/ptmr_evt.sv
module ptmr_evt
    import ptmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  req_e mode,
    input  logic sw_clr,
    input  logic ack,
    output logic pending,
    output logic irq,
    output logic dma_req
);
    typedef enum logic [1:0] {
        EV_IDLE    = 2'd0,
        EV_SWAIT   = 2'd1,
        EV_DMAWAIT = 2'd2
    } ev_state_e;

    ev_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= EV_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EV_IDLE:    if (fire) state_d = (mode == REQ_DMA) ? EV_DMAWAIT : EV_SWAIT;
            EV_SWAIT:   if (sw_clr && !fire) state_d = EV_IDLE;
            EV_DMAWAIT: if (ack) state_d = EV_IDLE;
            default:    state_d = EV_IDLE;
        endcase
    end

    always_comb begin
        pending = (state_q != EV_IDLE);
        irq     = (state_q == EV_SWAIT) && (mode == REQ_IRQ);
        dma_req = (state_q == EV_DMAWAIT);
    end

    // R9: an event never asks for both services at once
    a_r9_one_service: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({irq, dma_req}));
    // R11: an acknowledge frees a DMA-pending event
    a_r11_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && ack) |=> !pending);
    // R10: without an acknowledge, a DMA-pending event stays, whatever software writes
    a_r10_dma_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && !ack) |=> dma_req);

endmodule

// File: rtl/ptmr_top.sv
module ptmr_top
    import ptmr_pkg::*;
#(
    parameter int CW   = 32,
    parameter int PW   = 8,
    parameter int DIVW = 4,
    parameter int SYNC = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  bus_addr,
    input  logic        bus_wr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        tin,
    output logic        tout,
    output logic        irq,
    output logic [1:0]  dma_req,
    input  logic [1:0]  dma_ack
);
    localparam int NEV = 2;
    localparam logic [CW-1:0] C_ONE = 1;

    ctrl_t         ctrl_q;
    logic [CW-1:0] refv_q, capv_q, cnt_q;
    logic          tout_q;
    logic          cnt_ld, tick, match, cap_fire, pin_rise, pin_fall;
    logic [NEV-1:0] ev_fire, ev_clr, ev_pend, ev_irq, ev_dma;
    req_e          ev_mode [NEV];

    assign cnt_ld = bus_wr && (bus_addr == A_CNT);

    ptmr_sync #(.STAGES(SYNC)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin(tin), .rise(pin_rise), .fall(pin_fall)
    );

    ptmr_tick #(.PW(PW), .DIVW(DIVW)) u_tick (
        .clk(clk), .rst_n(rst_n), .en(ctrl_q.en), .src(ctrl_q.src),
        .ext_rise(pin_rise), .presc(ctrl_q.presc[PW-1:0]), .clr(cnt_ld), .tick(tick)
    );

    assign match = tick && (cnt_q == refv_q);

    always_comb begin
        unique case (ctrl_q.cap_edge)
            EDGE_RISE: cap_fire = pin_rise;
            EDGE_FALL: cap_fire = pin_fall;
            EDGE_BOTH: cap_fire = pin_rise | pin_fall;
            default:   cap_fire = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            refv_q <= '0;
            capv_q <= '0;
            cnt_q  <= '0;
            tout_q <= 1'b0;
        end else begin
            if (bus_wr && bus_addr == A_CTRL) ctrl_q <= ctrl_t'(bus_wdata[23:0]);
            if (bus_wr && bus_addr == A_REFV) refv_q <= bus_wdata[CW-1:0];
            if (cap_fire) capv_q <= cnt_q;
            if (cnt_ld)     cnt_q <= bus_wdata[CW-1:0];
            else if (tick)  cnt_q <= (match && ctrl_q.restart) ? '0 : cnt_q + C_ONE;
            tout_q <= ctrl_q.toggle ? (tout_q ^ match) : match;
        end
    end

    assign ev_fire    = {match, cap_fire};
    assign ev_mode[0] = ctrl_q.cap_req;
    assign ev_mode[1] = ctrl_q.match_req;

    generate
        for (genvar i = 0; i < NEV; i++) begin : g_ev
            assign ev_clr[i] = bus_wr && (bus_addr == A_STAT) && bus_wdata[i];
            ptmr_evt u_ev (
                .clk(clk), .rst_n(rst_n), .fire(ev_fire[i]), .mode(ev_mode[i]),
                .sw_clr(ev_clr[i]), .ack(dma_ack[i]), .pending(ev_pend[i]),
                .irq(ev_irq[i]), .dma_req(ev_dma[i])
            );
        end
    endgenerate

    assign tout    = tout_q;
    assign irq     = |ev_irq;
    assign dma_req = ev_dma;

    always_comb begin
        unique case (bus_addr)
            A_CTRL:  bus_rdata = {8'd0, ctrl_q};
            A_REFV:  bus_rdata = 32'(refv_q);
            A_CAPV:  bus_rdata = 32'(capv_q);
            A_CNT:   bus_rdata = 32'(cnt_q);
            A_STAT:  bus_rdata = {30'd0, ev_pend};
            default: bus_rdata = '0;
        endcase
    end

    // R2: the counter moves only on a tick or a load
    a_r2_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_ld && !tick) |=> $stable(cnt_q));
    // R6: a match with restart set returns the counter to zero
    a_r6_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (match && ctrl_q.restart && !cnt_ld) |=> (cnt_q == '0));
    // R8: a capture takes the counter value of the capture cycle
    a_r8_cap_latch: assert property (@(posedge clk) disable iff (!rst_n)
        cap_fire |=> (capv_q == $past(cnt_q)));

endmodule

// File: tb/sim_ptmr_top.sv
module sim_ptmr_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  addr = '0;
    logic        wr = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        tin = 1'b0;
    logic        tout, irq;
    logic [1:0]  dreq;
    logic [1:0]  dack = '0;
    int          total = 0;
    int          fails = 0;
    logic [31:0] v;

    localparam logic [2:0] CTRL = 3'd0, REFV = 3'd1, CAPV = 3'd2, CNT = 3'd3, STAT = 3'd4;

    always #5 clk = ~clk;

    ptmr_top u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata),
        .bus_rdata(rdata), .tin(tin), .tout(tout), .irq(irq), .dma_req(dreq), .dma_ack(dack)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wreg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); addr = a; wdata = d; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic rreg(input logic [2:0] a, output logic [31:0] r);
        @(negedge clk); addr = a; #1; r = rdata;
    endtask

    task automatic set_pin(input logic b);
        @(negedge clk); tin = b;
        repeat (5) @(negedge clk);
    endtask

    function automatic logic [31:0] ctl(input logic en, input logic [1:0] src, input logic [1:0] edg,
                                        input logic rs, input logic tg, input logic [1:0] cq,
                                        input logic [1:0] rq, input logic [7:0] ps);
        return {8'd0, ps, 4'd0, rq, cq, 1'b0, tg, rs, edg, src, en};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        total++; fails++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        int ms [5] = '{1, 2, 5, 13, 40};
        int ns [5] = '{0, 1, 2, 3, 5};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rreg(CTRL, v); chk("R1 ctrl", v, 0);
        rreg(CNT, v);  chk("R1 cnt", v, 0);
        rreg(CAPV, v); chk("R1 cap", v, 0);
        rreg(STAT, v); chk("R1 stat", v, 0);
        chk("R1 pins", {29'd0, tout, irq, |dreq}, 0);

        // R2 hold while disabled, and wrap
        wreg(CTRL, ctl(0, 0, 0, 0, 0, 0, 0, 0));
        wreg(CNT, 32'h55);
        repeat (10) @(posedge clk);
        rreg(CNT, v); chk("R2 hold", v, 32'h55);
        wreg(REFV, 32'h1000);
        wreg(CTRL, ctl(1, 0, 0, 0, 0, 0, 0, 0));
        wreg(CNT, 32'hFFFF_FFFE);
        repeat (3) @(posedge clk);
        rreg(CNT, v); chk("R2 wrap", v, 32'h1);

        // R3 sweep of prescale values on the direct system clock
        foreach (ns[i]) begin
            wreg(CTRL, ctl(1, 0, 0, 0, 0, 0, 0, 8'(ns[i])));
            foreach (ms[j]) begin
                wreg(CNT, 0);
                repeat (ms[j]) @(posedge clk);
                rreg(CNT, v); chk("R3 presc", v, 32'(ms[j] / (ns[i] + 1)));
            end
        end
        wreg(CTRL, ctl(1, 0, 0, 0, 0, 0, 0, 8'hFF));
        wreg(CNT, 0); repeat (511) @(posedge clk);
        rreg(CNT, v); chk("R3 div256 a", v, 1);
        wreg(CNT, 0); repeat (512) @(posedge clk);
        rreg(CNT, v); chk("R3 div256 b", v, 2);

        // R4 divide by sixteen ahead of the prescaler
        for (int n = 0; n < 3; n += 2) begin
            wreg(CTRL, ctl(1, 1, 0, 0, 0, 0, 0, 8'(n)));
            foreach (ms[j]) begin
                wreg(CNT, 0);
                repeat (ms[j] * 4) @(posedge clk);
                rreg(CNT, v); chk("R4 sys16", v, 32'((ms[j] * 4) / (16 * (n + 1))));
            end
        end

        // R5 external clock edges
        for (int n = 0; n < 3; n += 2) begin
            wreg(CTRL, ctl(1, 2, 0, 0, 0, 0, 0, 8'(n)));
            wreg(CNT, 0);
            for (int k = 0; k < 7; k++) begin
                @(negedge clk); tin = 1'b1; repeat (3) @(negedge clk);
                tin = 1'b0; repeat (3) @(negedge clk);
            end
            repeat (5) @(posedge clk);
            rreg(CNT, v); chk("R5 ext", v, 32'(7 / (n + 1)));
        end

        // R6 restart period sweep
        for (int r = 0; r < 5; r++) begin
            wreg(REFV, 32'(r));
            wreg(CTRL, ctl(1, 0, 0, 1, 0, 0, 0, 0));
            for (int m = 1; m < 12; m += 3) begin
                wreg(CNT, 0);
                repeat (m) @(posedge clk);
                rreg(CNT, v); chk("R6 restart", v, 32'(m % (r + 1)));
            end
        end
        wreg(REFV, 3);
        wreg(CTRL, ctl(1, 0, 0, 0, 0, 0, 0, 0));
        wreg(STAT, 3);
        wreg(CNT, 0);
        repeat (10) @(posedge clk);
        rreg(CNT, v);  chk("R6 free run", v, 10);
        rreg(STAT, v); chk("R6 match flag", v & 2, 2);

        // R7 pulse and toggle output
        begin
            int highs = 0;
            logic t0;
            wreg(REFV, 2);
            wreg(CTRL, ctl(1, 0, 0, 1, 0, 0, 0, 0));
            wreg(CNT, 0);
            repeat (30) begin @(negedge clk); if (tout) highs++; end
            chk("R7 pulses", 32'(highs), 10);
            wreg(CTRL, ctl(1, 0, 0, 1, 1, 0, 0, 0));
            wreg(CNT, 0); #1 t0 = tout;
            repeat (7) @(posedge clk); #2;
            chk("R7 toggle even", {31'd0, tout}, {31'd0, t0});
            wreg(CNT, 0); #1 t0 = tout;
            repeat (9) @(posedge clk); #2;
            chk("R7 toggle odd", {31'd0, tout}, {31'd0, ~t0});
        end

        // R8 capture edge selection
        wreg(CTRL, ctl(0, 3, 1, 0, 0, 0, 0, 0));
        wreg(STAT, 3);
        wreg(CNT, 32'h1234); set_pin(1);
        rreg(CAPV, v); chk("R8 rise cap", v, 32'h1234);
        rreg(STAT, v); chk("R8 rise flag", v & 1, 1);
        wreg(STAT, 1);
        rreg(STAT, v); chk("R10 w1c flag", v & 1, 0);
        wreg(CNT, 32'h99); set_pin(0);
        rreg(CAPV, v); chk("R8 fall ignored", v, 32'h1234);
        rreg(STAT, v); chk("R8 fall no flag", v & 1, 0);
        wreg(CTRL, ctl(0, 3, 2, 0, 0, 0, 0, 0));
        set_pin(1);
        rreg(CAPV, v); chk("R8 rise ignored", v, 32'h1234);
        wreg(CNT, 32'h77); set_pin(0);
        rreg(CAPV, v); chk("R8 fall cap", v, 32'h77);
        wreg(CTRL, ctl(0, 3, 3, 0, 0, 0, 0, 0));
        wreg(CNT, 5); set_pin(1);
        rreg(CAPV, v); chk("R8 both rise", v, 5);
        wreg(CNT, 6); set_pin(0);
        rreg(CAPV, v); chk("R8 both fall", v, 6);
        wreg(CTRL, ctl(0, 3, 0, 0, 0, 0, 0, 0));
        wreg(STAT, 3);
        wreg(CNT, 8); set_pin(1);
        rreg(CAPV, v); chk("R8 none cap", v, 6);
        rreg(STAT, v); chk("R8 none flag", v & 1, 0);

        // R9 capture in interrupt mode
        wreg(CTRL, ctl(0, 3, 3, 0, 0, 1, 0, 0));
        set_pin(0);
        chk("R9 cap irq", {31'd0, irq}, 1);
        wreg(STAT, 1);
        chk("R10 irq cleared", {31'd0, irq}, 0);

        // R9/R10/R11 match in DMA mode
        wreg(REFV, 3);
        wreg(CTRL, ctl(1, 0, 0, 0, 0, 0, 2, 0));
        wreg(CNT, 0);
        repeat (8) @(posedge clk);
        wreg(CTRL, ctl(0, 0, 0, 0, 0, 0, 2, 0));
        chk("R9 dma req", {30'd0, dreq}, 2);
        chk("R9 no irq", {31'd0, irq}, 0);
        wreg(STAT, 2);
        rreg(STAT, v); chk("R10 w1c ignored in dma", v & 2, 2);
        chk("R10 dma still", {30'd0, dreq}, 2);
        @(negedge clk); dack = 2'b10; @(negedge clk); dack = 2'b00;
        chk("R11 ack drops req", {30'd0, dreq}, 0);
        rreg(STAT, v); chk("R11 ack clears flag", v & 2, 0);

        // R11 acknowledge ignored for an interrupt-mode event
        wreg(CTRL, ctl(1, 0, 0, 0, 0, 0, 1, 0));
        wreg(CNT, 0);
        repeat (8) @(posedge clk);
        wreg(CTRL, ctl(0, 0, 0, 0, 0, 0, 1, 0));
        chk("R9 match irq", {31'd0, irq}, 1);
        @(negedge clk); dack = 2'b10; @(negedge clk); dack = 2'b00;
        chk("R11 ack ignored", {31'd0, irq}, 1);
        rreg(STAT, v); chk("R11 flag kept", v & 2, 2);
        wreg(STAT, 2);
        chk("R10 irq w1c", {31'd0, irq}, 0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule